// File: doc/BRIEF.md
# Lookahead Multicast-Aware Mesh Route Computation

This block is the route-computation stage of one input port of a two-dimensional mesh router. For every head flit it is given the router's own coordinates, the output port that the previous router already chose for this router (the carried lookahead port), a multicast flag and a short window of the packet's destination list. It then issues three results to the crossbar. The first is the output-port request for this router. The second is a packet status that tells the crossbar multiplexer control how to treat the flit: unicast, multicast that only passes through, or multicast that is also copied to the local port. The third is the output port that the neighbouring router will need, computed one hop ahead.

Unicast and multicast packets use the same dimension-order path. A parameter selects X-then-Y or Y-then-X at build time. Because both traffic types follow the same conformed routes, mixing them cannot add a routing cycle. A multicast packet carries an ordered list of destinations. At each intermediate destination it is absorbed (copied locally) and also forwarded, and the list window then advances. At its final destination it is delivered to the local port.

Only head flits are routed. Each virtual channel has a two-state controller with states VC_IDLE and VC_HOLD. The ACQUIRE transition goes from VC_IDLE to VC_HOLD when a head flit arrives. The REACQUIRE transition stays in VC_HOLD when a new head flit arrives and re-latches the route. The RELEASE transition goes from VC_HOLD to VC_IDLE on a tail flit or a single-flit packet. In VC_HOLD, body and tail flits reuse the latched route.

Top module: `mesh_la_route`

## Requirements
- R1: With ORDER=0 (X then Y), the route from node (nx,ny) to target (tx,ty) is chosen in this priority order: East (code 1, x+1) if tx>nx; West (code 2, x-1) if tx<nx; North (code 3, y+1) if ty>ny; South (code 4, y-1) if ty<ny; otherwise Local (code 0).
- R2: With ORDER=1 (Y then X), the Y comparison is applied before the X comparison, using the same port codes and directions as R1.
- R3: For a head flit, `out_port` equals the carried `in_la_port`. `out_la_port` is the route, computed at the neighbour reached through that port, toward the neighbour's target. `out_la_port` is Local whenever the carried port is Local.
- R4: A head flit with `in_mcast` low gets status 0 (unicast) and always targets `d0`.
- R5: A multicast head flit gets status 2 (absorb) when the current node equals `d0` and `in_rem` (the number of destinations listed after `d0`, saturating at 3) is nonzero. Any other multicast head flit gets status 1 (forward), including delivery at its last destination.
- R6: After an absorb, the list window seen by the neighbour is (`d1`,`d2`), with destinations remaining only if `in_rem`≥2. Otherwise the window is (`d0`,`d1`), with destinations remaining when `in_rem`≠0. If the neighbour equals the first entry of its window and destinations remain, the lookahead route targets the second entry; otherwise it targets the first.
- R7: Every accepted flit produces its result on the outputs exactly one clock after it is presented, with `out_vc` equal to its `in_vc`.
- R8: A body (type 1) or tail (type 2) flit on a VC in VC_HOLD reuses that VC's latched port, status and lookahead port and ignores its own routing inputs. A tail moves the VC to VC_IDLE.
- R9: A body or tail flit on a VC in VC_IDLE produces no output (`out_valid` stays low).
- R10: During and right after reset, `out_valid` is low and every VC is in VC_IDLE.
- R11: A single-flit packet (type 3) is routed like a head (type 0) but leaves its VC in VC_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A flit is presented this cycle |
| in_type | input | 2 | Flit type: 0 head, 1 body, 2 tail, 3 single |
| in_vc | input | VCW | Virtual channel of the flit |
| in_la_port | input | 3 | Port chosen for this router by the previous router |
| in_mcast | input | 1 | Packet is multicast |
| in_rem | input | 2 | Destinations listed after d0, saturating at 3 |
| cur_x | input | CW | This router's X coordinate |
| cur_y | input | CW | This router's Y coordinate |
| d0_x | input | CW | Current destination X |
| d0_y | input | CW | Current destination Y |
| d1_x | input | CW | Following destination X |
| d1_y | input | CW | Following destination Y |
| d2_x | input | CW | Destination after d1, X |
| d2_y | input | CW | Destination after d1, Y |
| out_valid | output | 1 | Result valid |
| out_vc | output | VCW | VC of the result |
| out_port | output | 3 | Output-port request at this router |
| out_status | output | 2 | 0 unicast, 1 multicast forward, 2 multicast absorb |
| out_la_port | output | 3 | Port the next router will use |

## Verification
Every result from this block is due on the first rising edge after its flit is presented. The driver therefore stamps each expected item with the cycle count plus one, and the monitor compares outputs at the falling edge of exactly that cycle. It flags both outputs that arrive without a matching expectation and expectations whose cycle passes with no valid output. Flits that must be dropped are checked on that same due cycle by confirming that `out_valid` stays low. Routes are checked for every source and destination pair of a 4x4 mesh under both dimension orders. Multicast walks compute each hop's expected status and lookahead port from the previous hop's expectation.

// File: rtl/noc_rc_pkg.sv
package noc_rc_pkg;

    typedef enum logic [2:0] {
        PORT_LOCAL = 3'd0,
        PORT_EAST  = 3'd1,
        PORT_WEST  = 3'd2,
        PORT_NORTH = 3'd3,
        PORT_SOUTH = 3'd4
    } port_e;

    typedef enum logic [1:0] {
        FL_HEAD   = 2'd0,
        FL_BODY   = 2'd1,
        FL_TAIL   = 2'd2,
        FL_SINGLE = 2'd3
    } flit_e;

    typedef enum logic [1:0] {
        ST_UNI    = 2'd0,
        ST_MC_FWD = 2'd1,
        ST_MC_ABS = 2'd2
    } status_e;

    typedef struct packed {
        port_e   port;
        status_e status;
        port_e   la;
    } route_t;

endpackage

// File: rtl/rc_step_unit.sv
module rc_step_unit
    import noc_rc_pkg::*;
#(
    parameter int CW = 2
) (
    input  logic [CW-1:0] node_x,
    input  logic [CW-1:0] node_y,
    input  port_e         dir,
    output logic [CW-1:0] nb_x,
    output logic [CW-1:0] nb_y
);
    localparam logic [CW-1:0] ONE = CW'(1);

    always_comb begin
        nb_x = node_x;
        nb_y = node_y;
        unique case (dir)
            PORT_EAST:  nb_x = node_x + ONE;
            PORT_WEST:  nb_x = node_x - ONE;
            PORT_NORTH: nb_y = node_y + ONE;
            PORT_SOUTH: nb_y = node_y - ONE;
            default:    ;
        endcase
    end
endmodule

// File: rtl/rc_dor_unit.sv
module rc_dor_unit
    import noc_rc_pkg::*;
#(
    parameter int CW    = 2,
    parameter int ORDER = 0
) (
    input  logic [CW-1:0] node_x,
    input  logic [CW-1:0] node_y,
    input  logic [CW-1:0] tgt_x,
    input  logic [CW-1:0] tgt_y,
    output port_e         port
);
    generate
        if (ORDER == 0) begin : g_xy
            always_comb begin
                if (tgt_x > node_x)      port = PORT_EAST;
                else if (tgt_x < node_x) port = PORT_WEST;
                else if (tgt_y > node_y) port = PORT_NORTH;
                else if (tgt_y < node_y) port = PORT_SOUTH;
                else                     port = PORT_LOCAL;
            end
            // R1: a Y move only once X is resolved
            always_comb begin
                assert_x_first_R1: assert (!((port == PORT_NORTH || port == PORT_SOUTH)
                                             && node_x != tgt_x));
            end
        end else begin : g_yx
            always_comb begin
                if (tgt_y > node_y)      port = PORT_NORTH;
                else if (tgt_y < node_y) port = PORT_SOUTH;
                else if (tgt_x > node_x) port = PORT_EAST;
                else if (tgt_x < node_x) port = PORT_WEST;
                else                     port = PORT_LOCAL;
            end
            // R2: an X move only once Y is resolved
            always_comb begin
                assert_y_first_R2: assert (!((port == PORT_EAST || port == PORT_WEST)
                                             && node_y != tgt_y));
            end
        end
    endgenerate
endmodule

// File: rtl/rc_vc_slot.sv
module rc_vc_slot
    import noc_rc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   hit,
    input  flit_e  ftype,
    input  route_t head_route,
    output logic   busy,
    output route_t held
);
    typedef enum logic {VC_IDLE, VC_HOLD} vc_state_e;

    vc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VC_IDLE: begin
                if (hit && ftype == FL_HEAD) state_d = VC_HOLD;          // ACQUIRE
            end
            VC_HOLD: begin
                if (hit && (ftype == FL_TAIL || ftype == FL_SINGLE))
                    state_d = VC_IDLE;                                    // RELEASE
                else if (hit && ftype == FL_HEAD)
                    state_d = VC_HOLD;                                    // REACQUIRE
            end
            default: state_d = VC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= VC_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) held <= '0;
        else if (hit && (ftype == FL_HEAD || ftype == FL_SINGLE)) held <= head_route;
    end

    assign busy = (state_q == VC_HOLD);

    assert_tail_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit && ftype == FL_TAIL |=> !busy);

    assert_single_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hit && ftype == FL_SINGLE |=> !busy);

endmodule

// File: rtl/mesh_la_route.sv
module mesh_la_route
    import noc_rc_pkg::*;
#(
    parameter int  CW    = 2,
    parameter int  NVC   = 4,
    parameter int  ORDER = 0,
    localparam int VCW   = (NVC > 1) ? $clog2(NVC) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [1:0]     in_type,
    input  logic [VCW-1:0] in_vc,
    input  logic [2:0]     in_la_port,
    input  logic           in_mcast,
    input  logic [1:0]     in_rem,
    input  logic [CW-1:0]  cur_x,
    input  logic [CW-1:0]  cur_y,
    input  logic [CW-1:0]  d0_x,
    input  logic [CW-1:0]  d0_y,
    input  logic [CW-1:0]  d1_x,
    input  logic [CW-1:0]  d1_y,
    input  logic [CW-1:0]  d2_x,
    input  logic [CW-1:0]  d2_y,
    output logic           out_valid,
    output logic [VCW-1:0] out_vc,
    output logic [2:0]     out_port,
    output logic [1:0]     out_status,
    output logic [2:0]     out_la_port
);
    port_e   carried;
    flit_e   ftype;
    logic    is_head, abs_here, erem_nz, fwd_ok;
    status_e head_status;
    logic [CW-1:0] e0_x, e0_y, e1_x, e1_y, nb_x, nb_y, tg_x, tg_y;
    port_e   la_raw;
    route_t  head_route, pick_route, r_q;
    logic [NVC-1:0] busy;
    route_t  held_r [NVC];

    assign carried = port_e'(in_la_port);
    assign ftype   = flit_e'(in_type);
    assign is_head = (ftype == FL_HEAD) || (ftype == FL_SINGLE);

    // classification at this router
    always_comb begin
        abs_here = in_mcast && (cur_x == d0_x) && (cur_y == d0_y) && (in_rem != 2'd0);
        if (!in_mcast)    head_status = ST_UNI;
        else if (abs_here) head_status = ST_MC_ABS;
        else              head_status = ST_MC_FWD;
    end

    // destination window as the neighbour will see it
    always_comb begin
        if (abs_here) begin
            e0_x = d1_x; e0_y = d1_y;
            e1_x = d2_x; e1_y = d2_y;
            erem_nz = (in_rem >= 2'd2);
        end else begin
            e0_x = d0_x; e0_y = d0_y;
            e1_x = d1_x; e1_y = d1_y;
            erem_nz = (in_rem != 2'd0);
        end
    end

    rc_step_unit #(.CW(CW)) u_step (
        .node_x (cur_x),
        .node_y (cur_y),
        .dir    (carried),
        .nb_x   (nb_x),
        .nb_y   (nb_y)
    );

    always_comb begin
        if (in_mcast && erem_nz && nb_x == e0_x && nb_y == e0_y) begin
            tg_x = e1_x; tg_y = e1_y;
        end else begin
            tg_x = e0_x; tg_y = e0_y;
        end
    end

    rc_dor_unit #(.CW(CW), .ORDER(ORDER)) u_dor (
        .node_x (nb_x),
        .node_y (nb_y),
        .tgt_x  (tg_x),
        .tgt_y  (tg_y),
        .port   (la_raw)
    );

    always_comb begin
        head_route.port   = carried;
        head_route.status = head_status;
        head_route.la     = (carried == PORT_LOCAL) ? PORT_LOCAL : la_raw;
    end

    generate
        for (genvar v = 0; v < NVC; v++) begin : g_vc
            rc_vc_slot u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .hit        (in_valid && in_vc == VCW'(v)),
                .ftype      (ftype),
                .head_route (head_route),
                .busy       (busy[v]),
                .held       (held_r[v])
            );
        end
    endgenerate

    assign fwd_ok     = in_valid && (is_head || busy[in_vc]);
    assign pick_route = is_head ? head_route : held_r[in_vc];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_vc    <= '0;
            r_q       <= '0;
        end else begin
            out_valid <= fwd_ok;
            if (fwd_ok) begin
                out_vc <= in_vc;
                r_q    <= pick_route;
            end
        end
    end

    assign out_port    = r_q.port;
    assign out_status  = r_q.status;
    assign out_la_port = r_q.la;

    assert_head_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && is_head |=> out_valid && out_vc == $past(in_vc));

    assert_unicast_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && is_head && !in_mcast |=> out_status == 2'd0);

    assert_idle_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !is_head && !busy[in_vc] |=> !out_valid);

    assert_hold_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && in_valid && !is_head && busy[in_vc] && in_vc == out_vc
        |=> out_valid && out_port == $past(out_port) && out_la_port == $past(out_la_port));

    assert_local_la_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_port == 3'd0 |-> out_la_port == 3'd0);

endmodule

// File: tb/mesh_la_route_tb_top.sv
module mesh_la_route_tb_top;

    typedef struct packed {
        logic       valid;
        logic [1:0] ftype;
        logic [1:0] vc;
        logic [2:0] la;
        logic       mcast;
        logic [1:0] rem;
        logic [1:0] cx, cy, d0x, d0y, d1x, d1y, d2x, d2y;
    } drv_t;

    typedef struct {
        int    due;
        int    vc, port, status, la;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    drv_t drv [2];
    logic       ov  [2];
    logic [1:0] ovc [2];
    logic [2:0] opt [2];
    logic [1:0] ost [2];
    logic [2:0] ola [2];
    exp_t q [2][$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mesh_la_route #(.CW(2), .NVC(4), .ORDER(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(drv[0].valid), .in_type(drv[0].ftype),
        .in_vc(drv[0].vc), .in_la_port(drv[0].la), .in_mcast(drv[0].mcast), .in_rem(drv[0].rem),
        .cur_x(drv[0].cx), .cur_y(drv[0].cy), .d0_x(drv[0].d0x), .d0_y(drv[0].d0y),
        .d1_x(drv[0].d1x), .d1_y(drv[0].d1y), .d2_x(drv[0].d2x), .d2_y(drv[0].d2y),
        .out_valid(ov[0]), .out_vc(ovc[0]), .out_port(opt[0]), .out_status(ost[0]),
        .out_la_port(ola[0]));

    mesh_la_route #(.CW(2), .NVC(4), .ORDER(1)) dut_yx_i (
        .clk(clk), .rst_n(rst_n), .in_valid(drv[1].valid), .in_type(drv[1].ftype),
        .in_vc(drv[1].vc), .in_la_port(drv[1].la), .in_mcast(drv[1].mcast), .in_rem(drv[1].rem),
        .cur_x(drv[1].cx), .cur_y(drv[1].cy), .d0_x(drv[1].d0x), .d0_y(drv[1].d0y),
        .d1_x(drv[1].d1x), .d1_y(drv[1].d1y), .d2_x(drv[1].d2x), .d2_y(drv[1].d2y),
        .out_valid(ov[1]), .out_vc(ovc[1]), .out_port(opt[1]), .out_status(ost[1]),
        .out_la_port(ola[1]));

    // reference routing from R1 / R2
    function automatic int dor(int ord, int nx, int ny, int tx, int ty);
        if (ord == 0) begin
            if (tx > nx) return 1;
            if (tx < nx) return 2;
            if (ty > ny) return 3;
            if (ty < ny) return 4;
        end else begin
            if (ty > ny) return 3;
            if (ty < ny) return 4;
            if (tx > nx) return 1;
            if (tx < nx) return 2;
        end
        return 0;
    endfunction

    function automatic int stx(int p, int x);
        if (p == 1) return (x + 1) % 4;
        if (p == 2) return (x + 3) % 4;
        return x;
    endfunction

    function automatic int sty(int p, int y);
        if (p == 3) return (y + 1) % 4;
        if (p == 4) return (y + 3) % 4;
        return y;
    endfunction

    function automatic drv_t mk(int ft, int vc, int la, int mc, int rem, int cx, int cy,
                                int ax, int ay, int bx, int by, int gx, int gy);
        drv_t d;
        d.valid = 1'b1;   d.ftype = 2'(ft); d.vc = 2'(vc); d.la = 3'(la);
        d.mcast = 1'(mc); d.rem = 2'(rem > 3 ? 3 : rem);
        d.cx = 2'(cx);  d.cy = 2'(cy);  d.d0x = 2'(ax); d.d0y = 2'(ay);
        d.d1x = 2'(bx); d.d1y = 2'(by); d.d2x = 2'(gx); d.d2y = 2'(gy);
        return d;
    endfunction

    // driver: presents a flit and pushes its expectation, due one cycle later (R7)
    task automatic issue(int w, drv_t d, bit has_exp, int ep, int es, int el, string req);
        @(negedge clk);
        drv[w] = d;
        if (has_exp) begin
            exp_t e;
            e.due = cyc + 1; e.vc = int'(d.vc); e.port = ep; e.status = es; e.la = el;
            e.req = req;
            q[w].push_back(e);
        end
    endtask

    task automatic idle(int w);
        @(negedge clk);
        drv[w].valid = 1'b0;
    endtask

    // the previous flit must leave no output on its due cycle
    task automatic expect_quiet(int w, string req);
        @(negedge clk);
        drv[w].valid = 1'b0;
        checks++;
        if (ov[w] !== 1'b0) begin
            failures++;
            $display("FAIL %s dut%0d: out_valid=%0d expected 0", req, w, ov[w]);
        end
    endtask

    // monitor: pops and compares at the due cycle
    always @(negedge clk) begin
        if (rst_n) begin
            for (int w = 0; w < 2; w++) begin
                if (q[w].size() > 0 && q[w][0].due == cyc) begin
                    exp_t e;
                    e = q[w].pop_front();
                    checks++;
                    if (ov[w] !== 1'b1 || int'(ovc[w]) != e.vc || int'(opt[w]) != e.port ||
                        int'(ost[w]) != e.status || int'(ola[w]) != e.la) begin
                        failures++;
                        $display("FAIL %s dut%0d: valid=%0d vc=%0d port=%0d status=%0d la=%0d expected valid=1 vc=%0d port=%0d status=%0d la=%0d",
                                 e.req, w, ov[w], ovc[w], opt[w], ost[w], ola[w],
                                 e.vc, e.port, e.status, e.la);
                    end
                end else if (ov[w] === 1'b1) begin
                    checks++;
                    failures++;
                    $display("FAIL R9 dut%0d: unexpected out_valid=1 port=%0d expected valid=0",
                             w, opt[w]);
                end
            end
        end
    end

    // multicast walk: each hop's expectation follows R3, R5 and R6
    task automatic mc_walk(int w, int vc, int n, int lx[4], int ly[4], int sx0, int sy0);
        int ptr, rem, cx, cy, carried, tgi, e0, nx, ny, la, st;
        bit ab, ernz;
        ptr = 0; rem = n - 1; cx = sx0; cy = sy0;
        tgi = (cx == lx[0] && cy == ly[0] && rem != 0) ? 1 : 0;
        carried = dor(w, cx, cy, lx[tgi], ly[tgi]);
        for (int hop = 0; hop < 24; hop++) begin
            ab   = (cx == lx[ptr] && cy == ly[ptr] && rem != 0);
            st   = ab ? 2 : 1;
            e0   = ab ? ptr + 1 : ptr;
            ernz = ab ? (rem >= 2) : (rem != 0);
            nx = stx(carried, cx); ny = sty(carried, cy);
            tgi = (ernz && nx == lx[e0] && ny == ly[e0]) ? e0 + 1 : e0;
            la = (carried == 0) ? 0 : dor(w, nx, ny, lx[tgi % 4], ly[tgi % 4]);
            issue(w, mk(3, vc, carried, 1, rem, cx, cy,
                        lx[ptr], ly[ptr],
                        (ptr + 1 < n) ? lx[ptr + 1] : 0, (ptr + 1 < n) ? ly[ptr + 1] : 0,
                        (ptr + 2 < n) ? lx[ptr + 2] : 0, (ptr + 2 < n) ? ly[ptr + 2] : 0),
                  1, carried, st, la, ab ? "R5/R6 absorb" : "R5/R6 forward");
            if (carried == 0) break;
            if (ab) begin ptr++; rem--; end
            cx = nx; cy = ny; carried = la;
        end
        idle(w);
    endtask

    initial begin
        int lx[4];
        int ly[4];
        int hp, hl, sp, sl;
        drv[0] = '0; drv[1] = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        checks++;   // R10 reset state
        if (ov[0] !== 1'b0 || ov[1] !== 1'b0) begin
            failures++;
            $display("FAIL R10: out_valid=%0d/%0d expected 0/0", ov[0], ov[1]);
        end
        rst_n = 1'b1;
        // R10: VCs start idle, so a body is dropped
        issue(0, mk(1, 0, 1, 0, 0, 0, 0, 3, 3, 0, 0, 0, 0), 0, 0, 0, 0, "");
        expect_quiet(0, "R10 idle after reset");

        // all pairs in a 4x4 mesh, both orders (R1 R2 R3 R4 R7 R11)
        for (int w = 0; w < 2; w++) begin
            for (int s = 0; s < 16; s++) begin
                for (int t = 0; t < 16; t++) begin
                    int c, l;
                    c = dor(w, s % 4, s / 4, t % 4, t / 4);
                    l = (c == 0) ? 0 : dor(w, stx(c, s % 4), sty(c, s / 4), t % 4, t / 4);
                    issue(w, mk(3, (s + t) % 4, c, 0, 0, s % 4, s / 4, t % 4, t / 4,
                                (t + 1) % 4, s % 4, 0, 0),
                          1, c, 0, l, (w == 0) ? "R1/R3/R4" : "R2/R3/R4");
                end
            end
            idle(w);
        end

        // multicast walks (R5 R6)
        lx = '{2, 2, 3, 0}; ly = '{0, 2, 3, 0};
        mc_walk(0, 0, 3, lx, ly, 0, 0);
        lx = '{0, 2, 3, 0}; ly = '{2, 2, 1, 0};
        mc_walk(1, 1, 3, lx, ly, 0, 0);
        lx = '{1, 3, 0, 0}; ly = '{1, 1, 0, 0};
        mc_walk(0, 2, 2, lx, ly, 1, 1);
        lx = '{2, 3, 3, 0}; ly = '{0, 0, 1, 0};
        mc_walk(0, 3, 3, lx, ly, 0, 0);
        lx = '{1, 1, 2, 3}; ly = '{2, 3, 3, 3};
        mc_walk(1, 0, 4, lx, ly, 1, 0);

        // per-VC hold and release (R8 R9 R11) on the X-then-Y instance
        hp = dor(0, 0, 0, 3, 2);
        hl = dor(0, stx(hp, 0), sty(hp, 0), 3, 2);
        issue(0, mk(0, 1, hp, 0, 0, 0, 0, 3, 2, 0, 0, 0, 0), 1, hp, 0, hl, "R8 head");
        issue(0, mk(1, 1, 4, 1, 2, 2, 2, 0, 0, 1, 1, 1, 1), 1, hp, 0, hl, "R8 body reuse");
        sp = dor(0, 0, 0, 0, 3);
        sl = dor(0, stx(sp, 0), sty(sp, 0), 0, 3);
        issue(0, mk(3, 2, sp, 0, 0, 0, 0, 0, 3, 0, 0, 0, 0), 1, sp, 0, sl, "R11 single");
        issue(0, mk(1, 1, 2, 0, 0, 3, 3, 1, 0, 0, 0, 0, 0), 1, hp, 0, hl, "R8 interleaved body");
        issue(0, mk(2, 1, 0, 1, 1, 1, 1, 1, 1, 2, 2, 0, 0), 1, hp, 0, hl, "R8 tail reuse");
        issue(0, mk(1, 1, 1, 0, 0, 0, 0, 3, 2, 0, 0, 0, 0), 0, 0, 0, 0, "");
        expect_quiet(0, "R8 released by tail");
        issue(0, mk(1, 2, 1, 0, 0, 0, 0, 3, 2, 0, 0, 0, 0), 0, 0, 0, 0, "");
        expect_quiet(0, "R11 single leaves VC idle");
        issue(0, mk(2, 3, 1, 0, 0, 0, 0, 3, 2, 0, 0, 0, 0), 0, 0, 0, 0, "");
        expect_quiet(0, "R9 tail on idle VC");

        repeat (3) @(negedge clk);
        for (int w = 0; w < 2; w++) begin
            checks++;
            if (q[w].size() != 0) begin
                failures++;
                $display("FAIL R7 dut%0d: pending=%0d expected 0", w, q[w].size());
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run not finished, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule